// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block routes each access that falls in the first megabyte of physical address space. For every request it picks one of two targets, main DRAM or the PCI bus, and raises a write-block flag when a write lands in a window that is set to read-only. The routing comes from a small set of configuration bytes. Seven attribute bytes cover the shadow area from C0000 to FFFFF. One control byte covers the 128 KB graphics/system-management window from A0000 to BFFFF, and that window also depends on a live system-management-mode input.

Configuration is written through a dword-addressed port with byte enables. Only lanes that land on the attribute bytes or on the control byte change state. Requests are decoded from the address, the direction and the mode input. The result is registered, so it appears one clock after the request. Addresses below A0000 and from 100000 upward always go to DRAM with writes allowed.

Top module: `legacy_win_decoder`

## Requirements
- R1: While reset is applied, and with no request after it, dec_valid_o, dec_pci_o and dec_wr_block_o are 0. Reset clears every attribute byte, so every shadow window goes to PCI. The control byte at offset 0x72 resets to 0x02, so A0000–BFFFF goes to PCI.
- R2: A request sampled on a rising edge sets dec_valid_o together with its decode at that edge. An edge with no request leaves all three outputs at 0.
- R3: An address below 0xA0000 or at or above 0x100000 decodes to DRAM (dec_pci_o=0) with dec_wr_block_o=0, for both reads and writes.
- R4: Window F0000–FFFFF takes its attribute from bits [5:4] of offset 0x59. The other bits of that byte have no effect.
- R5: The range C0000–EFFFF is divided into 12 segments of 16 KB. Segment i, based at C0000+i·0x4000, takes its attribute from bits [1:0] of the low nibble (i even) or the high nibble (i odd) of offset 0x5A+i/2. Nibble bits [3:2] have no effect.
- R6: Attribute 3 sends reads and writes to DRAM. Attribute 1 sends reads to DRAM; a write gives dec_wr_block_o=1 with dec_pci_o=0. Attributes 0 and 2 give dec_pci_o=1.
- R7: A configuration write at dword address cfg_addr_i[7:2] writes lane k (cfg_wdata_i[8k+7:8k]) to offset {cfg_addr_i[7:2],k} only when cfg_be_i[k]=1. Only offsets 0x59–0x5F and 0x72 hold state. A request presented in the cycle after the write edge decodes with the new value.
- R8: A0000–BFFFF goes to DRAM when bit 6 of offset 0x72 is 1, or when smm_i=1 and bit 3 is 1. Otherwise it goes to PCI. This window never sets dec_wr_block_o.
- R9: smm_i is sampled together with the request. A change on smm_i takes effect on the request presented in the same cycle.
- R10: dec_wr_block_o is only ever 1 for a write request, and never together with dec_pci_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address; bits [7:2] select the dword |
| cfg_be_i | input | 4 | Byte-lane enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| smm_i | input | 1 | System-management mode active |
| acc_valid_i | input | 1 | Access request valid |
| acc_addr_i | input | ADDR_W | Access physical address |
| acc_wr_i | input | 1 | Access is a write |
| dec_valid_o | output | 1 | Decode result valid |
| dec_pci_o | output | 1 | 1 = forward to PCI, 0 = DRAM |
| dec_wr_block_o | output | 1 | Write must be dropped (read-only window) |

## Verification
Every decode result is due on the first rising edge after the request is sampled. The bench drives a request on a falling edge and reads the outputs on the next falling edge, which is half a cycle after the edge that registers them. A configuration write is captured on its own rising edge. The bench presents the following request on the falling edge right after that write, so each reconfiguration check measures the one-cycle take-effect rule directly. The mode input changes on the same falling edge as the request it must govern, which tests that it takes effect in that same cycle.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  localparam logic [31:0] LOW_END   = 32'h000A_0000;
  localparam logic [31:0] SEG_BASE  = 32'h000C_0000;
  localparam logic [31:0] TOP_BASE  = 32'h000F_0000;
  localparam logic [31:0] MB_END    = 32'h0010_0000;
  localparam int          SEG_SHIFT = 14;

  typedef enum logic [1:0] {
    ATTR_PCI_A = 2'd0,
    ATTR_RO    = 2'd1,
    ATTR_PCI_B = 2'd2,
    ATTR_RW    = 2'd3
  } attr_e;

  typedef enum logic {
    TGT_DRAM = 1'b0,
    TGT_PCI  = 1'b1
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic wr_block;
  } route_t;

  function automatic route_t attr_route(attr_e a, logic wr);
    route_t r;
    case (a)
      ATTR_RW: begin r.tgt = TGT_DRAM; r.wr_block = 1'b0; end
      ATTR_RO: begin r.tgt = TGT_DRAM; r.wr_block = wr;   end
      default: begin r.tgt = TGT_PCI;  r.wr_block = 1'b0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lwd_cfg_regs.sv
module lwd_cfg_regs #(
  parameter logic [7:0] ATTR_BASE  = 8'h59,
  parameter int         ATTR_BYTES = 7,
  parameter logic [7:0] SMRAM_OFS  = 8'h72,
  parameter logic [7:0] SMRAM_RST  = 8'h02
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [7:0]              cfg_addr_i,
  input  logic [3:0]              cfg_be_i,
  input  logic [31:0]             cfg_wdata_i,
  output logic [ATTR_BYTES*8-1:0] attr_q_o,
  output logic [7:0]              smram_q_o
);
  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    localparam logic [7:0] OFS = 8'(int'(ATTR_BASE) + b);
    logic hit;
    assign hit = cfg_we_i && (cfg_addr_i[7:2] == OFS[7:2]) && cfg_be_i[OFS[1:0]];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  attr_q_o[b*8 +: 8] <= 8'h00;
      else if (hit) attr_q_o[b*8 +: 8] <= cfg_wdata_i[OFS[1:0]*8 +: 8];
    end
  end

  logic smram_hit;
  assign smram_hit = cfg_we_i && (cfg_addr_i[7:2] == SMRAM_OFS[7:2]) && cfg_be_i[SMRAM_OFS[1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smram_q_o <= SMRAM_RST;
    else if (smram_hit) smram_q_o <= cfg_wdata_i[SMRAM_OFS[1:0]*8 +: 8];
  end
endmodule

// File: rtl/lwd_shadow_lookup.sv
module lwd_shadow_lookup
  import lwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEG_CNT = 12,
  localparam int ATTR_BYTES = 1 + SEG_CNT / 2,
  localparam int IDX_W      = $clog2(SEG_CNT)
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ATTR_BYTES*8-1:0] attr_i,
  output attr_e                   attr_o
);
  logic [1:0]       seg_attr [SEG_CNT];
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;

  // byte 0 serves the top window; segments start at byte 1
  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    assign seg_attr[g] = attr_i[(1 + g / 2) * 8 + (g % 2) * 4 +: 2];
  end

  assign off = addr_i - ADDR_W'(SEG_BASE);
  assign idx = off[SEG_SHIFT +: IDX_W];

  always_comb begin
    attr_o = ATTR_PCI_A;
    if (addr_i >= ADDR_W'(TOP_BASE)) begin
      attr_o = attr_e'(attr_i[5:4]);
    end else begin
      for (int i = 0; i < SEG_CNT; i++)
        if (idx == IDX_W'(i)) attr_o = attr_e'(seg_attr[i]);
    end
  end
endmodule

// File: rtl/lwd_smram_gate.sv
module lwd_smram_gate (
  input  logic [7:0] smram_i,
  input  logic       smm_i,
  output logic       open_o
);
  // bit 6 forces open; bit 3 opens only in system-management mode
  assign open_o = smram_i[6] | (smm_i & smram_i[3]);
endmodule

// File: rtl/legacy_win_decoder.sv
module legacy_win_decoder
  import lwd_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         SEG_CNT   = 12,
  parameter logic [7:0] ATTR_BASE = 8'h59,
  parameter logic [7:0] SMRAM_OFS = 8'h72,
  parameter logic [7:0] SMRAM_RST = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              smm_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_wr_i,
  output logic              dec_valid_o,
  output logic              dec_pci_o,
  output logic              dec_wr_block_o
);
  localparam int ATTR_BYTES = 1 + SEG_CNT / 2;

  logic [ATTR_BYTES*8-1:0] attr_q;
  logic [7:0]              smram_q;
  attr_e                   shadow_attr;
  logic                    smram_open;
  route_t                  route;

  lwd_cfg_regs #(
    .ATTR_BASE (ATTR_BASE),
    .ATTR_BYTES(ATTR_BYTES),
    .SMRAM_OFS (SMRAM_OFS),
    .SMRAM_RST (SMRAM_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_be_i   (cfg_be_i),
    .cfg_wdata_i(cfg_wdata_i),
    .attr_q_o   (attr_q),
    .smram_q_o  (smram_q)
  );

  lwd_shadow_lookup #(
    .ADDR_W (ADDR_W),
    .SEG_CNT(SEG_CNT)
  ) u_lookup (
    .addr_i(acc_addr_i),
    .attr_i(attr_q),
    .attr_o(shadow_attr)
  );

  lwd_smram_gate u_gate (
    .smram_i(smram_q),
    .smm_i  (smm_i),
    .open_o (smram_open)
  );

  always_comb begin
    route = '{tgt: TGT_DRAM, wr_block: 1'b0};
    if (acc_addr_i < ADDR_W'(LOW_END)) begin
      route = '{tgt: TGT_DRAM, wr_block: 1'b0};
    end else if (acc_addr_i < ADDR_W'(SEG_BASE)) begin
      route = '{tgt: (smram_open ? TGT_DRAM : TGT_PCI), wr_block: 1'b0};
    end else if (acc_addr_i < ADDR_W'(MB_END)) begin
      route = attr_route(shadow_attr, acc_wr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o    <= 1'b0;
      dec_pci_o      <= 1'b0;
      dec_wr_block_o <= 1'b0;
    end else begin
      dec_valid_o    <= acc_valid_i;
      dec_pci_o      <= acc_valid_i & (route.tgt == TGT_PCI);
      dec_wr_block_o <= acc_valid_i & route.wr_block;
    end
  end
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smm_i,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_wr_i,
  input logic [7:0]        smram_q,
  input logic              dec_valid_o,
  input logic              dec_pci_o,
  input logic              dec_wr_block_o
);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] MB_HI = ADDR_W'(32'h0010_0000);

  // R2
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> dec_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!dec_pci_o && !dec_wr_block_o));

  // R3
  low_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i < A_LO) |=> (!dec_pci_o && !dec_wr_block_o));

  // R3
  high_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i >= MB_HI) |=> (!dec_pci_o && !dec_wr_block_o));

  // R8
  smram_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i >= A_LO && acc_addr_i < A_HI &&
     (smram_q[6] || (smm_i && smram_q[3]))) |=> (!dec_pci_o && !dec_wr_block_o));

  // R8
  smram_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i >= A_LO && acc_addr_i < A_HI &&
     !smram_q[6] && !(smm_i && smram_q[3])) |=> (dec_pci_o && !dec_wr_block_o));

  // R10
  block_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_wr_block_o |-> ($past(acc_wr_i) && !dec_pci_o));
endmodule

bind legacy_win_decoder lwd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .smm_i         (smm_i),
  .acc_valid_i   (acc_valid_i),
  .acc_addr_i    (acc_addr_i),
  .acc_wr_i      (acc_wr_i),
  .smram_q       (smram_q),
  .dec_valid_o   (dec_valid_o),
  .dec_pci_o     (dec_pci_o),
  .dec_wr_block_o(dec_wr_block_o)
);

// File: tb/legacy_win_decoder_test.sv
module legacy_win_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smm = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic        dec_valid, dec_pci, dec_blk;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  legacy_win_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
    .smm_i(smm), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_wr_i(acc_wr),
    .dec_valid_o(dec_valid), .dec_pci_o(dec_pci), .dec_wr_block_o(dec_blk)
  );

  // {smm, wr, addr, exp_pci, exp_blk} with the table configuration loaded
  localparam int NVEC = 18;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0009_FFFF, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h000A_0000, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'h000B_FFFF, 1'b1, 1'b0},
    {1'b0, 1'b0, 32'h000C_0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h000C_3FFF, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h000C_4000, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h000C_8000, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h000C_FFFF, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h000D_0000, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h000D_4000, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h000D_C000, 1'b0, 1'b1},
    {1'b0, 1'b0, 32'h000E_0000, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h000E_FFFF, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h000F_0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h000F_FFFF, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h0010_0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0}
  };

  task automatic chk3(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,pci,blk} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic w, input logic s,
                        input logic ep, input logic eb);
    acc_valid = 1'b1; acc_addr = a; acc_wr = w; smm = s;
    @(negedge clk);
    acc_valid = 1'b0;
    chk3(req, {dec_valid, dec_pci, dec_blk}, {1'b1, ep, eb});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk3("R1 in reset", {dec_valid, dec_pci, dec_blk}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk3("R2 idle after reset", {dec_valid, dec_pci, dec_blk}, 3'b000);
    // R1: reset attributes forward shadow windows, control byte closes A window
    access("R1 top window reset", 32'h000F_8000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R1 segment reset",    32'h000D_8000, 1'b0, 1'b0, 1'b1, 1'b0);
    access("R1 A window reset",   32'h000A_8000, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk3("R2 idle no request", {dec_valid, dec_pci, dec_blk}, 3'b000);

    // table configuration: 0x59=10 0x5A=31 0x5B=20 0x5C=03 0x5D=13 0x5E=00 0x5F=33
    cfg_write(8'h58, 4'b1110, 32'h2031_10AA);
    cfg_write(8'h5C, 4'b1111, 32'h3300_1303);
    for (int i = 0; i < NVEC; i++) begin
      access($sformatf("R3/R4/R5/R6/R8 vec %0d", i), VEC[i][33:2], VEC[i][34], VEC[i][35],
             VEC[i][1], VEC[i][0]);
    end

    // R5 nibble bits [3:2] ignored: 0x5A=0D -> seg0 read-only, seg1 PCI
    cfg_write(8'h58, 4'b0100, 32'h000D_0000);
    access("R5 nibble mask seg0", 32'h000C_0000, 1'b1, 1'b0, 1'b0, 1'b1);
    access("R7 next access seg1", 32'h000C_4000, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7 lane for offset 0x58 only: no register changes
    cfg_write(8'h58, 4'b0001, 32'hFFFF_FFFF);
    access("R7 disabled lanes ignored", 32'h000C_4000, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4 top window attribute from bits [5:4]
    cfg_write(8'h58, 4'b0010, 32'h0000_3000);
    access("R4 top rw", 32'h000F_8000, 1'b1, 1'b0, 1'b0, 1'b0);
    cfg_write(8'h58, 4'b0010, 32'h0000_CF00);
    access("R4 other bits ignored", 32'h000F_8000, 1'b0, 1'b0, 1'b1, 1'b0);

    // R7 lanes around 0x72 leave it alone
    cfg_write(8'h70, 4'b1011, 32'hFFFF_FFFF);
    access("R7 control byte untouched", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    cfg_write(8'h70, 4'b0100, 32'h0008_0000);
    access("R8 bit3 without smm", 32'h000A_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R9 smm same cycle",   32'h000B_FFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    access("R9 smm drop",         32'h000B_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_write(8'h70, 4'b0100, 32'h0040_0000);
    access("R8 bit6 open",        32'h000A_4000, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10 read in read-only window never blocked
    access("R10 read not blocked", 32'h000D_C000, 1'b0, 1'b0, 1'b0, 1'b0);

    @(negedge clk);
    chk3("R2 final idle", {dec_valid, dec_pci, dec_blk}, 3'b000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule